// File: doc/BRIEF.md
# Spike-Timing Synaptic Weight Learner

This block adapts one synaptic weight from the relative timing of two spike streams: the presynaptic spikes that arrive at the synapse and the postsynaptic spikes that its target neuron emits. Every clock cycle is one simulation time step. A free-running step counter supplies the time. Each side has a timestamp register that records the step of its latest spike, together with a valid flag.

A new spike on one side is paired with the latest spike on the other side, provided that spike is still inside a learning window of `WIN_L` steps. A pair in which the presynaptic spike came first raises the weight. The reverse order lowers it. The amount is a base step shifted right by the interval divided by 2^`SHIFT_LOG2`, so spikes that lie close together change the weight more. The weight is a signed value clamped to configurable limits. Each spike pair produces exactly one update, and the new weight appears on the port in the cycle after the spike is sampled.

Top module: `stdp_weight_unit`

## Requirements
- R1: After reset the weight equals `W_INIT` and both timestamp valid flags are clear. A spike on either side that comes before any spike on the other side forms no pair and leaves the weight unchanged.
- R2: A postsynaptic spike alone in a step t, with the latest presynaptic spike at step t-d and 1 <= d <= `WIN_L`, raises the weight by `BASE_STEP >> (d >> SHIFT_LOG2)`.
- R3: A presynaptic spike alone in a step t, with the latest postsynaptic spike at step t-d and 1 <= d <= `WIN_L`, lowers the weight by `BASE_STEP >> (d >> SHIFT_LOG2)`.
- R4: When the interval d is greater than `WIN_L`, the spike forms no pair and the weight does not change.
- R5: When pre and post spikes fall in the same step, the weight does not change. Both timestamps take that step, so later spikes on either side pair with it.
- R6: The weight never goes below `W_MIN` or above `W_MAX`. An update that would cross a limit leaves the weight at that limit.
- R7: A new spike pairs only with the most recent spike on the other side. A repeated spike on one side replaces that side's timestamp.
- R8: The weight port shows the result of a spike in the cycle after the clock edge that samples the spike. In a step with no spike the weight holds its value.
- R9: A timestamp older than the window never forms a pair, even after the `TS_W`-bit step counter has wrapped. For example, with `TS_W`=8 a post spike 259 steps after a pre spike causes no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per time step |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_spike_i | input | 1 | Presynaptic spike arrival in this step |
| post_spike_i | input | 1 | Postsynaptic spike emission in this step |
| weight_o | output | WEIGHT_W | Current signed synaptic weight |

## Verification
The assertions check on every cycle the properties that hold at every step. The weight stays inside its limits. A post-only step never lowers the weight, and a pre-only step never raises it. A step with both spikes, or with neither, leaves the weight unchanged. A freshly written timestamp is valid with an age of one, and no valid timestamp ages past one beyond the window. The assertions cannot show the exact size of each change, which timestamp a spike pairs with, or the behaviour after the step counter wraps. For those the bench runs an exhaustive sweep of intervals in both orders, plus targeted same-step, nearest-spike, saturation and wrap scenarios, plus a long pseudo-random spike train, and compares each step with an arithmetic model that uses unbounded time.

// File: rtl/stdp_pkg.sv
// stdp_pkg: shared constants and types of the spike-timing weight learner.
// Assumes: side index 0 is the presynaptic stream and index 1 the postsynaptic stream.
package stdp_pkg;

    localparam int SIDE_PRE  = 0;
    localparam int SIDE_POST = 1;
    localparam int N_SIDES   = 2;

    // Outcome of the pairing decision for one time step.
    typedef enum logic [1:0] {
        PAIR_NONE   = 2'd0,
        PAIR_CAUSAL = 2'd1,
        PAIR_ANTI   = 2'd2,
        PAIR_SAME   = 2'd3
    } pair_kind_e;

endpackage

// File: rtl/stdp_step_timer.sv
// stdp_step_timer: free-running time-step counter, one increment per clock.
// Assumes: the counter wraps modulo 2^TS_W; users subtract modulo the same width.
module stdp_step_timer #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now_o
);

    // Advance the step count each clock; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) now_o <= '0;
        else        now_o <= now_o + 1'b1;
    end

endmodule

// File: rtl/stdp_stamp.sv
// stdp_stamp: latest-spike timestamp of one side, with a valid flag and its age.
// Assumes: WIN_L + 1 < 2^TS_W. The flag drops once the age passes the window,
// which happens before the wrapping age could alias back into the window.
module stdp_stamp #(
    parameter int TS_W  = 8,
    parameter int WIN_L = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TS_W-1:0] now_i,
    input  logic            spike_i,
    output logic            valid_o,
    output logic [TS_W-1:0] age_o
);

    localparam logic [TS_W-1:0] WIN_V   = TS_W'(WIN_L);
    localparam logic [TS_W-1:0] AGE_CAP = TS_W'(WIN_L + 1);

    logic [TS_W-1:0] stamp_q;

    // Wrap-safe age of the stored spike.
    assign age_o = now_i - stamp_q;

    // Record a new spike, or retire a timestamp that has left the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp_q <= '0;
            valid_o <= 1'b0;
        end else if (spike_i) begin
            stamp_q <= now_i;
            valid_o <= 1'b1;
        end else if (valid_o && (age_o > WIN_V)) begin
            valid_o <= 1'b0;
        end
    end

    // A spike leaves a valid timestamp that is one step old in the next cycle.
    p_stamp_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spike_i |=> (valid_o && (age_o == TS_W'(1))));

    // A valid timestamp never ages past one step beyond the window.
    p_stale_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (age_o <= AGE_CAP));

endmodule

// File: rtl/stdp_pair_eval.sv
// stdp_pair_eval: decides whether this step's spike forms a pair, in which
// order, and the size of the change.
// Assumes: ages come from stdp_stamp, so a valid age is at least one step.
module stdp_pair_eval
    import stdp_pkg::*;
#(
    parameter int TS_W       = 8,
    parameter int WIN_L      = 12,
    parameter int WEIGHT_W   = 8,
    parameter int BASE_STEP  = 16,
    parameter int SHIFT_LOG2 = 2
) (
    input  logic                pre_spike_i,
    input  logic                post_spike_i,
    input  logic                pre_valid_i,
    input  logic [TS_W-1:0]     pre_age_i,
    input  logic                post_valid_i,
    input  logic [TS_W-1:0]     post_age_i,
    output pair_kind_e          kind_o,
    output logic [WEIGHT_W-1:0] mag_o
);

    localparam logic [TS_W-1:0]     WIN_V  = TS_W'(WIN_L);
    localparam logic [WEIGHT_W-1:0] BASE_V = WEIGHT_W'(BASE_STEP);

    logic            partner_valid;
    logic [TS_W-1:0] partner_age;
    logic            in_window;
    logic [TS_W-1:0] shift_amt;

    // The partner of a post spike is the stored pre spike, and the reverse.
    always_comb begin
        partner_valid = post_spike_i ? pre_valid_i : post_valid_i;
        partner_age   = post_spike_i ? pre_age_i   : post_age_i;
    end

    // Window test on the partner's age.
    assign in_window = partner_valid && (partner_age != '0) && (partner_age <= WIN_V);

    // Step size falls by half for each 2^SHIFT_LOG2 steps of interval.
    assign shift_amt = partner_age >> SHIFT_LOG2;
    assign mag_o     = BASE_V >> shift_amt;

    // Classify the step by spike order.
    always_comb begin
        if (pre_spike_i && post_spike_i)  kind_o = PAIR_SAME;
        else if (post_spike_i && in_window) kind_o = PAIR_CAUSAL;
        else if (pre_spike_i && in_window)  kind_o = PAIR_ANTI;
        else                                kind_o = PAIR_NONE;
    end

endmodule

// File: rtl/stdp_weight_acc.sv
// stdp_weight_acc: holds the signed weight and applies one clamped update per pair.
// Assumes: W_MIN <= W_INIT <= W_MAX, and all three fit in WEIGHT_W signed bits.
module stdp_weight_acc
    import stdp_pkg::*;
#(
    parameter int WEIGHT_W = 8,
    parameter int W_MIN    = -40,
    parameter int W_MAX    = 40,
    parameter int W_INIT   = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  pair_kind_e                 kind_i,
    input  logic [WEIGHT_W-1:0]        mag_i,
    output logic signed [WEIGHT_W-1:0] weight_o
);

    localparam int XW = WEIGHT_W + 2;
    localparam logic signed [XW-1:0]       MIN_X  = XW'(W_MIN);
    localparam logic signed [XW-1:0]       MAX_X  = XW'(W_MAX);
    localparam logic signed [WEIGHT_W-1:0] INIT_V = WEIGHT_W'(W_INIT);

    logic signed [XW-1:0]       cur_x;
    logic signed [XW-1:0]       mag_x;
    logic signed [XW-1:0]       sum_x;
    logic signed [WEIGHT_W-1:0] next_w;

    // Widen the weight and the step so the sum cannot overflow.
    assign cur_x = {{2{weight_o[WEIGHT_W-1]}}, weight_o};
    assign mag_x = $signed({2'b00, mag_i});

    // Raise, lower or keep the weight, then clamp it to the limits.
    always_comb begin
        unique case (kind_i)
            PAIR_CAUSAL: sum_x = cur_x + mag_x;
            PAIR_ANTI:   sum_x = cur_x - mag_x;
            default:     sum_x = cur_x;
        endcase
        if (sum_x < MIN_X)      next_w = WEIGHT_W'(MIN_X);
        else if (sum_x > MAX_X) next_w = WEIGHT_W'(MAX_X);
        else                    next_w = WEIGHT_W'(sum_x);
    end

    // Weight register.
    always_ff @(posedge clk) begin
        if (!rst_n) weight_o <= INIT_V;
        else        weight_o <= next_w;
    end

    // The stored weight always lies inside the limits.
    p_weight_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_x >= MIN_X) && (cur_x <= MAX_X));

endmodule

// File: rtl/stdp_weight_unit.sv
// stdp_weight_unit: spike-timing weight learner for a single synapse.
// One clock cycle is one time step. Spikes are sampled at a clock edge, and the
// updated weight is visible in the following cycle.
// Assumes: WIN_L + 1 < 2^TS_W.
module stdp_weight_unit
    import stdp_pkg::*;
#(
    parameter int TS_W       = 8,
    parameter int WIN_L      = 12,
    parameter int WEIGHT_W   = 8,
    parameter int BASE_STEP  = 16,
    parameter int SHIFT_LOG2 = 2,
    parameter int W_MIN      = -40,
    parameter int W_MAX      = 40,
    parameter int W_INIT     = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pre_spike_i,
    input  logic                       post_spike_i,
    output logic signed [WEIGHT_W-1:0] weight_o
);

    logic [TS_W-1:0]     now;
    logic [N_SIDES-1:0]  spk;
    logic [N_SIDES-1:0]  side_valid;
    logic [TS_W-1:0]     side_age [N_SIDES];
    pair_kind_e          kind;
    logic [WEIGHT_W-1:0] mag;

    assign spk[SIDE_PRE]  = pre_spike_i;
    assign spk[SIDE_POST] = post_spike_i;

    stdp_step_timer #(.TS_W(TS_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (now)
    );

    // One timestamp register per side.
    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        stdp_stamp #(.TS_W(TS_W), .WIN_L(WIN_L)) u_stamp (
            .clk     (clk),
            .rst_n   (rst_n),
            .now_i   (now),
            .spike_i (spk[s]),
            .valid_o (side_valid[s]),
            .age_o   (side_age[s])
        );
    end

    stdp_pair_eval #(
        .TS_W(TS_W), .WIN_L(WIN_L), .WEIGHT_W(WEIGHT_W),
        .BASE_STEP(BASE_STEP), .SHIFT_LOG2(SHIFT_LOG2)
    ) u_eval (
        .pre_spike_i  (pre_spike_i),
        .post_spike_i (post_spike_i),
        .pre_valid_i  (side_valid[SIDE_PRE]),
        .pre_age_i    (side_age[SIDE_PRE]),
        .post_valid_i (side_valid[SIDE_POST]),
        .post_age_i   (side_age[SIDE_POST]),
        .kind_o       (kind),
        .mag_o        (mag)
    );

    stdp_weight_acc #(
        .WEIGHT_W(WEIGHT_W), .W_MIN(W_MIN), .W_MAX(W_MAX), .W_INIT(W_INIT)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind_i   (kind),
        .mag_i    (mag),
        .weight_o (weight_o)
    );

    // A post-only step never lowers the weight.
    p_causal_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (post_spike_i && !pre_spike_i) |=> (weight_o >= $past(weight_o)));

    // A pre-only step never raises the weight.
    p_anti_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_spike_i && !post_spike_i) |=> (weight_o <= $past(weight_o)));

    // Coincident spikes leave the weight unchanged.
    p_same_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_spike_i && post_spike_i) |=> $stable(weight_o));

    // A step without spikes leaves the weight unchanged.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_spike_i && !post_spike_i) |=> $stable(weight_o));

endmodule

// File: tb/tb_stdp_weight_unit.sv
`timescale 1ns/1ps
module tb_stdp_weight_unit;

    localparam int TS_W = 8, WIN_L = 12, WW = 8, BASE = 16, SH = 2;
    localparam int WMIN = -40, WMAX = 40, WINIT = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pre_i = 1'b0;
    logic post_i = 1'b0;
    logic signed [WW-1:0] weight_o;

    int tests = 0;
    int fails = 0;

    // Bench model, with unbounded time.
    int mnow, pt, qt, mw;
    bit pv, qv;

    stdp_weight_unit #(
        .TS_W(TS_W), .WIN_L(WIN_L), .WEIGHT_W(WW), .BASE_STEP(BASE),
        .SHIFT_LOG2(SH), .W_MIN(WMIN), .W_MAX(WMAX), .W_INIT(WINIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pre_spike_i(pre_i),
        .post_spike_i(post_i), .weight_o(weight_o)
    );

    always #4 clk = ~clk;

    function automatic int clampw(input int v);
        if (v < WMIN) return WMIN;
        if (v > WMAX) return WMAX;
        return v;
    endfunction

    function automatic int stepsize(input int d);
        if (d < 1 || d > WIN_L) return 0;
        return BASE >> (d >> SH);
    endfunction

    task automatic model(input logic p, input logic q);
        if (p && q) begin
            pt = mnow; qt = mnow; pv = 1; qv = 1;
        end else if (q) begin
            if (pv) mw = clampw(mw + stepsize(mnow - pt));
            qt = mnow; qv = 1;
        end else if (p) begin
            if (qv) mw = clampw(mw - stepsize(mnow - qt));
            pt = mnow; pv = 1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pre_i = 1'b0; post_i = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        mnow = 0; pv = 0; qv = 0; pt = 0; qt = 0; mw = WINIT;
    endtask

    task automatic step(input logic p, input logic q);
        @(negedge clk);
        pre_i = p; post_i = q;
        @(posedge clk);
        model(p, q);
        mnow++;
        #2 pre_i = 1'b0; post_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    task automatic check(input string req, input int exp);
        tests++;
        if (int'(weight_o) != exp) begin
            fails++;
            $display("FAIL %s: weight actual %0d expected %0d (step %0d)",
                     req, weight_o, exp, mnow);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;

        // R1: reset value, and no pair before the other side has spiked
        do_reset();
        check("R1 reset value", WINIT);
        step(1'b0, 1'b1);
        check("R1 post without prior pre", WINIT);
        do_reset();
        step(1'b1, 1'b0);
        check("R1 pre without prior post", WINIT);

        // R2 R3 R4: every interval in both orders, from a fresh reset each time
        for (int d = 1; d <= WIN_L + 3; d++) begin
            do_reset();
            step(1'b1, 1'b0);
            idle(d - 1);
            step(1'b0, 1'b1);
            check(d <= WIN_L ? "R2 causal step" : "R4 causal outside window",
                  clampw(WINIT + stepsize(d)));
            do_reset();
            step(1'b0, 1'b1);
            idle(d - 1);
            step(1'b1, 1'b0);
            check(d <= WIN_L ? "R3 anti-causal step" : "R4 anti-causal outside window",
                  clampw(WINIT - stepsize(d)));
        end

        // R5: coincident spikes change nothing but set both timestamps
        do_reset();
        step(1'b1, 1'b0);
        idle(1);
        step(1'b1, 1'b1);
        check("R5 same step no change", WINIT);
        idle(2);
        step(1'b0, 1'b1);
        check("R5 post pairs with same-step pre", WINIT + 16);
        do_reset();
        step(1'b1, 1'b1);
        idle(4);
        step(1'b1, 1'b0);
        check("R5 pre pairs with same-step post", WINIT - 8);

        // R6: saturation at both limits
        do_reset();
        step(1'b1, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            step(1'b0, 1'b1);
            check("R6 upper clamp", mw);
        end
        check("R6 at maximum", WMAX);
        do_reset();
        step(1'b0, 1'b1);
        for (int k = 1; k <= 3; k++) begin
            step(1'b1, 1'b0);
            check("R6 lower clamp", mw);
        end
        check("R6 at minimum", WMIN);

        // R7: only the most recent pre counts (d=1 gives 16, d=6 would give 8)
        do_reset();
        step(1'b1, 1'b0);
        idle(4);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        check("R7 nearest pre", WINIT + 16);

        // R8: weight holds across idle steps
        idle(20);
        check("R8 idle hold", WINIT + 16);

        // R9: a stale stamp does not pair after the counter wraps (age mod 256 = 3)
        do_reset();
        step(1'b1, 1'b0);
        idle(258);
        step(1'b0, 1'b1);
        check("R9 wrapped stale pre", WINIT);

        // R2 R3 R7 R8: pseudo-random spike train against the model
        do_reset();
        lfsr = 16'hACE1;
        for (int n = 0; n < 2000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] & lfsr[3], lfsr[5] & lfsr[9]);
            check("R8 random train", mw);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule